// File: doc/BRIEF.md
# Multicast hash address filter

This block sits at the head of an Ethernet receive path and decides whether an incoming frame is kept. It watches the first six bytes of each frame, which hold the destination MAC address. It then makes one accept or reject decision per frame. A start-of-frame strobe marks the first address byte, and later bytes are counted only while `byte_valid_i` is high.

While the address streams in, the block runs an Ethernet CRC-32 over it. The CRC uses polynomial 0x04C11DB7 with a non-reflected register, starts from all ones, and takes each byte least significant bit first. No final inversion is applied. The top six bits of the result, `crc[31:26]`, select one bit of a 64-entry hash table. Multicast frames can be passed by this table lookup, passed wholesale, or dropped, depending on a three-bit mode register. Broadcast frames are always kept. Unicast frames are kept on an exact match with the station address. Promiscuous mode keeps everything.

Three write ports load the station address, the hash table and the mode. Each write takes effect from the following clock edge.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `decision_valid_o` and `accept_o` are low, and the station address, hash table and mode registers all hold zero.
- R2: `decision_valid_o` rises in the cycle after the sixth address byte is taken. The first byte is the one presented with `sof_i`. The decision then stays high, with `accept_o` unchanged, until the next byte presented with `sof_i` clears it.
- R3: `accept_o` is low whenever `decision_valid_o` is low.
- R4: Some bytes have no effect on the decision. These are bytes with `byte_valid_i` low, bytes after the sixth one of a frame, and bytes that arrive before any `sof_i`.
- R5: When mode bit 0 (promiscuous) is set, every frame is accepted, whatever the hash table or station address holds.
- R6: The all-ones destination address is always accepted.
- R7: A unicast frame is accepted, when promiscuous mode is clear, only on an exact 48-bit match with the station address. A frame is unicast when bit 0 of its first byte is 0. Station address bits 47:40 are compared with the first received byte, and bits 7:0 with the sixth.
- R8: When mode bit 1 (all-multicast) is set, every multicast frame is accepted. A frame is multicast when bit 0 of its first byte is 1.
- R9: When mode bit 2 (hashed multicast) is set, a multicast frame is accepted if hash table bit `crc[31:26]` is 1. The CRC is the one defined above, computed over the six address bytes in arrival order.
- R10: A non-broadcast multicast frame is rejected when mode bits 0, 1 and 2 are all clear, or when only mode bit 2 is set and the indexed table bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Marks the current valid byte as the first address byte |
| byte_valid_i | input | 1 | Receive byte valid |
| byte_i | input | 8 | Receive byte |
| station_we_i | input | 1 | Station address write strobe |
| station_addr_i | input | 48 | Station address, first received byte in bits 47:40 |
| hash_we_i | input | 1 | Hash table write strobe |
| hash_table_i | input | 64 | Hash table, bit n is entry n |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Bit 0 promiscuous, bit 1 all-multicast, bit 2 hashed multicast |
| decision_valid_o | output | 1 | Decision for the current frame is available |
| accept_o | output | 1 | Frame accepted (meaningful while decision valid) |

## Verification
The bench targets the byte order of the station address by flipping a single bit in the first byte and, separately, in the last byte. A design that reversed the order would accept one of these mismatches. In the hash tests, the table holds only the indexed bit, or every bit except that one. This catches an index taken from the wrong CRC bits, a reflected CRC, or a final inversion, since any of these would select a different entry. Idle gaps, stray bytes before the first start-of-frame, and trailing bytes after the address are also injected. A design that counted them would decide on a shifted address or overwrite a decision it should be holding.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int unsigned HASH_BITS  = 6;
  localparam int unsigned TABLE_N    = 1 << HASH_BITS;

  typedef struct packed {
    logic hash_en;
    logic all_mc;
    logic promisc;
  } mode_t;
endpackage

// File: rtl/mhf_crc_byte.sv
module mhf_crc_byte #(
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [8:0][CRC_W-1:0] st;
  assign st[0] = crc_i;
  // data bits enter LSB first, register shifts toward MSB
  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb = st[b][CRC_W-1] ^ data_i[b];
    assign st[b+1] = {st[b][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end
  assign crc_o = st[8];
endmodule

// File: rtl/mhf_dest_capture.sv
module mhf_dest_capture #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7,
  parameter int unsigned HASH_BITS = 6,
  localparam int unsigned ADDR_W = 8 * ADDR_BYTES,
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sof_i,
  input  logic                 byte_valid_i,
  input  logic [7:0]           byte_i,
  output logic                 sof_take_o,
  output logic                 last_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [HASH_BITS-1:0] hash_idx_o
);
  logic [CNT_W-1:0] cnt_q, pos;
  logic [ADDR_BYTES-1:0][7:0] bytes_q;
  logic [CRC_W-1:0] crc_q, crc_in, crc_nx;
  logic take;

  assign take       = byte_valid_i & (sof_i | (cnt_q < CNT_W'(ADDR_BYTES)));
  assign pos        = sof_i ? '0 : cnt_q;
  assign sof_take_o = byte_valid_i & sof_i;
  assign last_o     = take & (pos == CNT_W'(ADDR_BYTES - 1));
  assign crc_in     = sof_i ? '1 : crc_q;

  mhf_crc_byte #(.CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .crc_i (crc_in),
    .data_i(byte_i),
    .crc_o (crc_nx)
  );

  assign hash_idx_o = crc_nx[CRC_W-1 -: HASH_BITS];

  // byte k of the address lands in bits [ADDR_W-1-8k -: 8]
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
    assign addr_o[ADDR_W-1-8*k -: 8] = (pos == CNT_W'(k)) ? byte_i : bytes_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_W'(ADDR_BYTES);  // idle until first sof
      crc_q   <= '1;
      bytes_q <= '0;
    end else if (take) begin
      cnt_q        <= pos + CNT_W'(1);
      crc_q        <= crc_nx;
      bytes_q[pos] <= byte_i;
    end
  end
endmodule

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TABLE_N = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               station_we_i,
  input  logic [ADDR_W-1:0]  station_addr_i,
  input  logic               hash_we_i,
  input  logic [TABLE_N-1:0] hash_table_i,
  input  logic               mode_we_i,
  input  mode_t              mode_i,
  output logic [ADDR_W-1:0]  station_o,
  output logic [TABLE_N-1:0] table_o,
  output mode_t              mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      station_o <= '0;
      table_o   <= '0;
      mode_o    <= '0;
    end else begin
      if (station_we_i) station_o <= station_addr_i;
      if (hash_we_i)    table_o   <= hash_table_i;
      if (mode_we_i)    mode_o    <= mode_i;
    end
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned HASH_BITS = 6,
  localparam int unsigned TABLE_N = 1 << HASH_BITS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [HASH_BITS-1:0] hash_idx_i,
  input  logic [ADDR_W-1:0]    station_i,
  input  logic [TABLE_N-1:0]   table_i,
  input  mode_t                mode_i,
  output logic                 accept_o
);
  logic is_mc, is_bc, uc_hit, mc_hit;
  assign is_mc    = addr_i[ADDR_W-8];  // group bit: bit 0 of first byte
  assign is_bc    = &addr_i;
  assign uc_hit   = !is_mc && (addr_i == station_i);
  assign mc_hit   = is_mc && (mode_i.all_mc || (mode_i.hash_en && table_i[hash_idx_i]));
  assign accept_o = mode_i.promisc || is_bc || uc_hit || mc_hit;
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sof_i,
  input  logic         byte_valid_i,
  input  logic [7:0]   byte_i,
  input  logic         station_we_i,
  input  logic [47:0]  station_addr_i,
  input  logic         hash_we_i,
  input  logic [63:0]  hash_table_i,
  input  logic         mode_we_i,
  input  logic [2:0]   mode_i,
  output logic         decision_valid_o,
  output logic         accept_o
);
  logic                 sof_take, last;
  logic [ADDR_W-1:0]    addr;
  logic [HASH_BITS-1:0] hash_idx;
  logic [ADDR_W-1:0]    station;
  logic [TABLE_N-1:0]   table_q;
  mode_t                mode_q;
  logic                 accept_c;

  mhf_dest_capture #(
    .ADDR_BYTES(ADDR_BYTES), .CRC_W(CRC_W), .POLY(CRC_POLY), .HASH_BITS(HASH_BITS)
  ) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sof_i       (sof_i),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .sof_take_o  (sof_take),
    .last_o      (last),
    .addr_o      (addr),
    .hash_idx_o  (hash_idx)
  );

  mhf_cfg_regs #(.ADDR_W(ADDR_W), .TABLE_N(TABLE_N)) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .station_we_i  (station_we_i),
    .station_addr_i(station_addr_i),
    .hash_we_i     (hash_we_i),
    .hash_table_i  (hash_table_i),
    .mode_we_i     (mode_we_i),
    .mode_i        (mode_t'(mode_i)),
    .station_o     (station),
    .table_o       (table_q),
    .mode_o        (mode_q)
  );

  mhf_decide #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_decide (
    .addr_i    (addr),
    .hash_idx_i(hash_idx),
    .station_i (station),
    .table_i   (table_q),
    .mode_i    (mode_q),
    .accept_o  (accept_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
    end else if (last) begin
      decision_valid_o <= 1'b1;
      accept_o         <= accept_c;
    end else if (sof_take) begin
      decision_valid_o <= 1'b0;
      accept_o         <= 1'b0;
    end
  end
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sof_i,
  input logic       byte_valid_i,
  input logic       first_bit_i,
  input logic       mode_we_i,
  input logic [1:0] mode_lo_i,
  input logic       decision_valid_o,
  input logic       accept_o
);
  logic promisc_sh, allmc_sh, mc_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      promisc_sh <= 1'b0;
      allmc_sh   <= 1'b0;
      mc_sh      <= 1'b0;
    end else begin
      if (mode_we_i) begin
        promisc_sh <= mode_lo_i[0];
        allmc_sh   <= mode_lo_i[1];
      end
      if (sof_i && byte_valid_i) mc_sh <= first_bit_i;
    end
  end

  assert_rise_after_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(decision_valid_o) |-> $past(byte_valid_i));

  assert_sof_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && byte_valid_i) |=> !decision_valid_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decision_valid_o && !(sof_i && byte_valid_i)) |=> (decision_valid_o && $stable(accept_o)));

  assert_no_accept_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decision_valid_o |-> !accept_o);

  assert_promisc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(decision_valid_o) && $past(promisc_sh)) |-> accept_o);

  assert_all_mc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(decision_valid_o) && $past(allmc_sh) && $past(mc_sh)) |-> accept_o);
endmodule

bind mcast_hash_filter mhf_checker u_mhf_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sof_i           (sof_i),
  .byte_valid_i    (byte_valid_i),
  .first_bit_i     (byte_i[0]),
  .mode_we_i       (mode_we_i),
  .mode_lo_i       (mode_i[1:0]),
  .decision_valid_o(decision_valid_o),
  .accept_o        (accept_o)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0, byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic        station_we_i = 1'b0, hash_we_i = 1'b0, mode_we_i = 1'b0;
  logic [47:0] station_addr_i = '0;
  logic [63:0] hash_table_i = '0;
  logic [2:0]  mode_i = '0;
  logic        decision_valid_o, accept_o;

  int checks = 0, fails = 0;
  logic [47:0] sh_station = '0;
  logic [63:0] sh_table = '0;
  logic [2:0]  sh_mode = '0;

  always #4 clk_i = ~clk_i;

  mcast_hash_filter u_mcast_hash_filter (.*);

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] b = a[47-8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[31] ^ b[j];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a);
    logic mc = a[40];
    if (sh_mode[0]) return 1'b1;             // R5
    if (a == '1) return 1'b1;                 // R6
    if (!mc) return a == sh_station;          // R7
    if (sh_mode[1]) return 1'b1;              // R8
    if (sh_mode[2]) return sh_table[ref_idx(a)]; // R9
    return 1'b0;                              // R10
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [47:0] st, input logic [63:0] tb, input logic [2:0] md);
    station_we_i = 1; station_addr_i = st;
    hash_we_i = 1; hash_table_i = tb;
    mode_we_i = 1; mode_i = md;
    @(negedge clk_i);
    station_we_i = 0; hash_we_i = 0; mode_we_i = 0;
    sh_station = st; sh_table = tb; sh_mode = md;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input int extra, input bit gaps);
    logic exp = ref_accept(a);
    for (int i = 0; i < 6; i++) begin
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          byte_valid_i = 0; sof_i = 0; byte_i = 8'($urandom); @(negedge clk_i);
        end
      end
      byte_valid_i = 1; sof_i = (i == 0); byte_i = a[47-8*i -: 8];
      @(negedge clk_i);
      if (i == 0) chk({req, " R2 sof clears"}, decision_valid_o, 0);
    end
    byte_valid_i = 0; sof_i = 0;
    chk({req, " R2 valid"}, decision_valid_o, 1);
    chk(req, accept_o, exp);
    for (int e = 0; e < extra; e++) begin
      byte_valid_i = 1; byte_i = 8'($urandom); @(negedge clk_i);
    end
    byte_valid_i = 0;
    if (extra > 0) begin
      chk({req, " R4 trailing bytes"}, decision_valid_o, 1);
      chk({req, " R4 trailing bytes"}, accept_o, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R1 valid after reset", decision_valid_o, 0);
    chk("R3 accept after reset", accept_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    // R4: bytes before any sof
    for (int i = 0; i < 8; i++) begin
      byte_valid_i = 1; byte_i = 8'hFF; @(negedge clk_i);
    end
    byte_valid_i = 0;
    chk("R4 no sof yet", decision_valid_o, 0);
    chk("R3 idle accept", accept_o, 0);
    // R1: zero station matches all-zero unicast, zero mode drops multicast
    frame("R1 reset station", 48'h0, 0, 0);
    frame("R1 reset mode R10", 48'h01_00_5E_12_34_56, 0, 0);
    frame("R6 broadcast", 48'hFFFF_FFFF_FFFF, 3, 1);
    cfg(48'h02_11_22_33_44_55, '0, 3'b000);
    frame("R7 match", 48'h02_11_22_33_44_55, 2, 1);
    frame("R7 first byte bit", 48'h06_11_22_33_44_55, 0, 0);
    frame("R7 last byte bit", 48'h02_11_22_33_44_54, 0, 0);
    frame("R10 multicast dropped", 48'h03_11_22_33_44_55, 0, 0);
    cfg(48'h02_11_22_33_44_55, '0, 3'b001);
    frame("R5 promisc unicast", 48'h0A_BB_CC_DD_EE_FF, 0, 0);
    frame("R5 promisc multicast", 48'h01_BB_CC_DD_EE_FF, 0, 1);
    cfg(48'h02_11_22_33_44_55, '0, 3'b010);
    frame("R8 all multicast", 48'h33_33_00_00_00_01, 0, 0);
    frame("R8 unicast miss", 48'h32_33_00_00_00_01, 0, 0);
    begin
      logic [47:0] ma = 48'h01_00_5E_00_00_01;
      logic [5:0] ix = ref_idx(ma);
      cfg(48'h02_11_22_33_44_55, 64'b1 << ix, 3'b100);
      frame("R9 hash hit", ma, 0, 0);
      chk("R9 hash hit direct", accept_o, 1);
      cfg(48'h02_11_22_33_44_55, ~(64'b1 << ix), 3'b100);
      frame("R10 hash miss", ma, 0, 0);
      chk("R10 hash miss direct", accept_o, 0);
      cfg(48'h02_11_22_33_44_55, '1, 3'b000);
      frame("R10 hash disabled", ma, 0, 0);
    end
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [47:0] a;
      int kind;
      if (n % 12 == 0)
        cfg({$urandom, 16'($urandom)} & ~48'h01_00_00_00_00_00,
            {$urandom, $urandom}, 3'($urandom_range(0, 7) & (($urandom_range(0, 3) == 0) ? 7 : 6)));
      kind = $urandom_range(0, 9);
      a = {$urandom, 16'($urandom)};
      case (kind)
        0, 1: a = sh_station;
        2:    a = '1;
        3, 4, 5: a[40] = 1'b1;
        default: ;
      endcase
      frame(a[40] ? "R9 random multicast" : "R7 random unicast", a,
            $urandom_range(0, 3), $urandom_range(0, 1));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule